// File: doc/BRIEF.md
# Three-Level Leg Switching Sequencer

This block commands the twelve gate signals of a three-phase, three-level diode-clamped converter during one sampling period. A controller computes the state list and the dwell times elsewhere. At a sample boundary it presents up to four phase-state vectors, each with a dwell count in clock ticks, and pulses `start`. The block plays the vectors in list order. It turns the level of each phase into a four-switch gate pattern and keeps break-before-make timing on every leg. It pulses `done` when the period has been played out.

Small vectors come in redundant pairs. The two members of a pair give the same line voltage but push the neutral point in opposite directions. The controller marks list entries as swappable and drives a balance request. When the request is high, each marked entry is replaced by its redundant partner before it is played. The neutral-point controller can therefore pick, for example, between the sequence (1,0,0)→(1,0,-1)→(0,0,-1)→(0,-1,-1) and its mirror without rebuilding the list. A leg that is asked to jump straight between the two outer levels raises an error pulse.

Top module: `npc_leg_sequencer`

## Requirements
- R1: A phase level is a 2-bit code: 01 = +1, 00 = 0, 11 = -1, and 10 is treated as 0. Phase A occupies vector bits [1:0], B [3:2] and C [5:4]. Entry i of a list sits at `vec_list[6*i +: 6]` and `dwell_list[12*i +: 12]`. Leg p drives `gates[4*p +: 4]` with bit 0 = S1 (top) through bit 3 = S4 (bottom). A settled leg shows 0011 for +1, 0110 for 0 and 1100 for -1.
- R2: After reset all gates are low and `busy`, `done` and `step_err` are low. They stay that way until the first start.
- R3: `start` latches the list, the dwell counts, the swap mask and the balance request in the cycle it is sampled. Input changes after that have no effect on the period being played.
- R4: Call E0 the edge that samples `start`. Entries are played in list order. Entry k becomes the commanded level at edge E0 + (sum of the dwells before k) and is held for its own dwell count.
- R5: An entry with dwell 0 is skipped. It never reaches the gates, and the gates go straight from the previous played entry to the next one.
- R6: `done` is high for exactly one cycle, starting at edge E0 + (total dwell). If every dwell is 0, `done` rises at E0 itself. `busy` falls with `done`, and the gates then hold the last played state.
- R7: When the commanded level of a leg changes at edge E, the switches that must turn off go low at E+1. The switches that must turn on go high at E + `dead_ticks` + 2.
- R8: With `bal_req` high, a swappable entry (its `swap_mask` bit set) is replaced by its redundant partner. If no phase is at -1, every phase steps down one level. Otherwise, if no phase is at +1, every phase steps up one level. Otherwise the entry is played unchanged. With `bal_req` low the mask has no effect.
- R9: `step_err` pulses for one cycle, starting at the edge where a new state is loaded, when any phase of the new state is the opposite outer level of the current state (+1↔-1). The state is still played.
- R10: A `start` during a running period aborts it and begins the new list at once. The aborted list gives no `done`.
- R11: No leg ever has S1 and S3, S2 and S4, or S1 and S4 on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Sample-boundary pulse; latches the list |
| bal_req | input | 1 | Neutral-point balance request; selects redundant partners |
| vec_list | input | 24 | Four phase-state vectors, entry 0 in the low bits |
| dwell_list | input | 48 | Four 12-bit dwell counts in clock ticks |
| swap_mask | input | 4 | Per-entry flag: entry may be swapped for its partner |
| dead_ticks | input | 6 | Dead-time count applied to turn-on edges |
| gates | output | 12 | Four gate signals for each of the three legs |
| busy | output | 1 | Period in progress |
| done | output | 1 | One-cycle pulse when the last dwell expires |
| step_err | output | 1 | One-cycle pulse on a direct outer-to-outer step |

## Verification
A wrong dwell counter or a wrong skip search moves gate edges and the `done` pulse away from their cumulative dwell sums. The bench therefore samples gates a few cycles either side of each expected edge. A fault in the dead-time counter or in the change detection in a leg shows up within `dead_ticks`+2 cycles as a gate pattern that is the wrong intersection of old and new decode. Wrong partner selection or a wrong jump detector is visible from the first settled pattern of the swapped entry, or from the `step_err` cycle itself.

// File: rtl/npc_seq_pkg.sv
package npc_seq_pkg;
  localparam int PHASES   = 3;
  localparam int LVL_W    = 2;
  localparam int VEC_W    = PHASES * LVL_W;
  localparam int LEG_SW   = 4;

  localparam logic [1:0] LV_ZERO = 2'b00;
  localparam logic [1:0] LV_POS  = 2'b01;
  localparam logic [1:0] LV_NEG  = 2'b11;

  function automatic logic [1:0] norm_lvl(input logic [1:0] l);
    return (l == 2'b10) ? LV_ZERO : l;
  endfunction

  function automatic logic [LEG_SW-1:0] lvl_to_gates(input logic [1:0] l);
    case (norm_lvl(l))
      LV_POS:  return 4'b0011;
      LV_NEG:  return 4'b1100;
      default: return 4'b0110;
    endcase
  endfunction

  function automatic logic [VEC_W-1:0] norm_vec(input logic [VEC_W-1:0] v);
    logic [VEC_W-1:0] r;
    for (int p = 0; p < PHASES; p++) r[p*LVL_W +: LVL_W] = norm_lvl(v[p*LVL_W +: LVL_W]);
    return r;
  endfunction

  function automatic logic [VEC_W-1:0] redundant_partner(input logic [VEC_W-1:0] v);
    logic [VEC_W-1:0] n, r;
    logic has_pos, has_neg;
    n = norm_vec(v);
    has_pos = 1'b0;
    has_neg = 1'b0;
    for (int p = 0; p < PHASES; p++) begin
      if (n[p*LVL_W +: LVL_W] == LV_POS) has_pos = 1'b1;
      if (n[p*LVL_W +: LVL_W] == LV_NEG) has_neg = 1'b1;
    end
    r = n;
    if (!has_neg) begin
      for (int p = 0; p < PHASES; p++)
        r[p*LVL_W +: LVL_W] = (n[p*LVL_W +: LVL_W] == LV_POS) ? LV_ZERO : LV_NEG;
    end else if (!has_pos) begin
      for (int p = 0; p < PHASES; p++)
        r[p*LVL_W +: LVL_W] = (n[p*LVL_W +: LVL_W] == LV_NEG) ? LV_ZERO : LV_POS;
    end
    return r;
  endfunction

  function automatic logic outer_jump(input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b);
    logic j;
    j = 1'b0;
    for (int p = 0; p < PHASES; p++) begin
      if ((norm_lvl(a[p*LVL_W +: LVL_W]) == LV_POS && norm_lvl(b[p*LVL_W +: LVL_W]) == LV_NEG) ||
          (norm_lvl(a[p*LVL_W +: LVL_W]) == LV_NEG && norm_lvl(b[p*LVL_W +: LVL_W]) == LV_POS))
        j = 1'b1;
    end
    return j;
  endfunction
endpackage

// File: rtl/npc_seq_ctrl.sv
module npc_seq_ctrl
  import npc_seq_pkg::*;
#(
  parameter int N_STATES = 4,
  parameter int DWELL_W  = 12
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic                        bal_req,
  input  logic [N_STATES*VEC_W-1:0]   vec_in,
  input  logic [N_STATES*DWELL_W-1:0] dwell_in,
  input  logic [N_STATES-1:0]         swap_in,
  output logic [VEC_W-1:0]            lvl_q,
  output logic                        en_q,
  output logic                        busy_q,
  output logic                        done_q,
  output logic                        err_q
);
  localparam int IDX_W = (N_STATES > 1) ? $clog2(N_STATES) : 1;

  logic [VEC_W-1:0]   in_vec  [N_STATES];
  logic [DWELL_W-1:0] in_dw   [N_STATES];
  logic [VEC_W-1:0]   vec_mem [N_STATES];
  logic [DWELL_W-1:0] dw_mem  [N_STATES];
  logic [IDX_W-1:0]   idx_q, first_in, next_idx;
  logic [DWELL_W-1:0] rem_q;
  logic               found_in, found_nx;

  always_comb begin
    found_in = 1'b0;
    first_in = '0;
    for (int i = N_STATES - 1; i >= 0; i--) begin
      in_dw[i]  = dwell_in[i*DWELL_W +: DWELL_W];
      in_vec[i] = (bal_req && swap_in[i]) ? redundant_partner(vec_in[i*VEC_W +: VEC_W])
                                          : norm_vec(vec_in[i*VEC_W +: VEC_W]);
      if (in_dw[i] != '0) begin
        found_in = 1'b1;
        first_in = IDX_W'(i);
      end
    end
  end

  always_comb begin
    found_nx = 1'b0;
    next_idx = '0;
    for (int i = N_STATES - 1; i >= 0; i--) begin
      if (i > int'(idx_q) && dw_mem[i] != '0) begin
        found_nx = 1'b1;
        next_idx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (start) begin
      for (int i = 0; i < N_STATES; i++) begin
        vec_mem[i] <= in_vec[i];
        dw_mem[i]  <= in_dw[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= '0;
      en_q   <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      idx_q  <= '0;
      rem_q  <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (start) begin
        en_q <= 1'b1;
        if (found_in) begin
          lvl_q  <= in_vec[first_in];
          err_q  <= outer_jump(lvl_q, in_vec[first_in]);
          idx_q  <= first_in;
          rem_q  <= in_dw[first_in] - DWELL_W'(1);
          busy_q <= 1'b1;
        end else begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (busy_q) begin
        if (rem_q != '0) begin
          rem_q <= rem_q - DWELL_W'(1);
        end else if (found_nx) begin
          lvl_q <= vec_mem[next_idx];
          err_q <= outer_jump(lvl_q, vec_mem[next_idx]);
          idx_q <= next_idx;
          rem_q <= dw_mem[next_idx] - DWELL_W'(1);
        end else begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  // R6: done lasts one cycle unless a fresh all-zero list restarts it
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    (done_q && !start) |=> !done_q);
  // R4: level is held while dwell remains
  a_r4_hold_level: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !start && rem_q != '0) |=> $stable(lvl_q));
  // R9: an error pulse only accompanies a change of commanded state
  a_r9_err_on_change: assert property (@(posedge clk) disable iff (rst)
    err_q |-> !$stable(lvl_q));
  // R2: nothing runs before the first start
  a_r2_idle_until_start: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> (!busy_q && !done_q));
endmodule

// File: rtl/npc_leg_gate.sv
module npc_leg_gate
  import npc_seq_pkg::*;
#(
  parameter int DEAD_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LVL_W-1:0]  lvl,
  input  logic              en,
  input  logic [DEAD_W-1:0] dead,
  output logic [LEG_SW-1:0] gate_q
);
  logic [LEG_SW-1:0] tgt, tgt_q;
  logic [DEAD_W-1:0] cnt_q;

  assign tgt = en ? lvl_to_gates(lvl) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= '0;
      tgt_q  <= '0;
      cnt_q  <= '0;
    end else begin
      tgt_q <= tgt;
      if (tgt != tgt_q) begin
        gate_q <= gate_q & tgt;
        cnt_q  <= '0;
      end else if (|(tgt & ~gate_q)) begin
        if (cnt_q >= dead) begin
          gate_q <= tgt;
        end else begin
          gate_q <= gate_q & tgt;
          cnt_q  <= cnt_q + DEAD_W'(1);
        end
      end
    end
  end

  // R11: no conducting path across either clamp pair
  a_r11_no_shoot: assert property (@(posedge clk) disable iff (rst)
    !(gate_q[0] && gate_q[2]) && !(gate_q[1] && gate_q[3]) && !(gate_q[0] && gate_q[3]));
  // R7: a switch not in the previous target is already off
  a_r7_off_first: assert property (@(posedge clk) disable iff (rst)
    (gate_q & ~$past(tgt)) == '0);
  // R7: a turn-on only follows a settled target
  a_r7_on_after_settle: assert property (@(posedge clk) disable iff (rst)
    (|(gate_q & ~$past(gate_q))) |-> ($past(tgt) == $past(tgt_q)));
endmodule

// File: rtl/npc_leg_sequencer.sv
module npc_leg_sequencer
  import npc_seq_pkg::*;
#(
  parameter int N_STATES = 4,
  parameter int DWELL_W  = 12,
  parameter int DEAD_W   = 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic                        bal_req,
  input  logic [N_STATES*VEC_W-1:0]   vec_list,
  input  logic [N_STATES*DWELL_W-1:0] dwell_list,
  input  logic [N_STATES-1:0]         swap_mask,
  input  logic [DEAD_W-1:0]           dead_ticks,
  output logic [PHASES*LEG_SW-1:0]    gates,
  output logic                        busy,
  output logic                        done,
  output logic                        step_err
);
  logic [VEC_W-1:0] lvl;
  logic             en;

  npc_seq_ctrl #(.N_STATES(N_STATES), .DWELL_W(DWELL_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .bal_req(bal_req),
    .vec_in(vec_list), .dwell_in(dwell_list), .swap_in(swap_mask),
    .lvl_q(lvl), .en_q(en), .busy_q(busy), .done_q(done), .err_q(step_err)
  );

  for (genvar p = 0; p < PHASES; p++) begin : g_leg
    npc_leg_gate #(.DEAD_W(DEAD_W)) u_leg (
      .clk(clk), .rst(rst), .lvl(lvl[p*LVL_W +: LVL_W]), .en(en),
      .dead(dead_ticks), .gate_q(gates[p*LEG_SW +: LEG_SW])
    );
  end
endmodule

// File: tb/npc_leg_sequencer_bench.sv
module npc_leg_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        bal_req = 1'b0;
  logic [23:0] vec_list = '0;
  logic [47:0] dwell_list = '0;
  logic [3:0]  swap_mask = '0;
  logic [5:0]  dead_ticks = 6'd2;
  logic [11:0] gates;
  logic        busy, done, step_err;

  int checks = 0;
  int errors = 0;
  int ix = 0;

  always #10 clk = ~clk;

  npc_leg_sequencer u_npc_leg_sequencer (
    .clk(clk), .rst(rst), .start(start), .bal_req(bal_req), .vec_list(vec_list),
    .dwell_list(dwell_list), .swap_mask(swap_mask), .dead_ticks(dead_ticks),
    .gates(gates), .busy(busy), .done(done), .step_err(step_err)
  );

  function automatic logic [1:0] enc(input int l);
    return (l > 0) ? 2'b01 : (l < 0) ? 2'b11 : 2'b00;
  endfunction
  function automatic logic [5:0] vv(input int a, input int b, input int c);
    return {enc(c), enc(b), enc(a)};
  endfunction
  function automatic logic [11:0] gx(input logic [5:0] v);
    logic [11:0] g;
    for (int p = 0; p < 3; p++)
      case (v[2*p +: 2])
        2'b01:   g[4*p +: 4] = 4'b0011;
        2'b11:   g[4*p +: 4] = 4'b1100;
        default: g[4*p +: 4] = 4'b0110;
      endcase
    return g;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at ix=%0d actual=%h expected=%h", req, ix, act, exp);
    end
  endtask

  task automatic wait_to(input int n);
    while (ix < n) begin
      @(negedge clk);
      ix++;
    end
  endtask

  task automatic launch(input logic [5:0] v0, v1, v2, v3, input int d0, d1, d2, d3,
                        input logic [3:0] mask, input logic bal);
    vec_list   = {v3, v2, v1, v0};
    dwell_list = {12'(d3), 12'(d2), 12'(d1), 12'(d0)};
    swap_mask  = mask;
    bal_req    = bal;
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ix = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check("R2 gates", 32'(gates), 32'h0);
    check("R2 busy/done/err", {29'b0, busy, done, step_err}, 32'h0);
  endtask

  task automatic t_basic_sequence();
    logic [5:0] v [4];
    v[0] = vv(1,0,0); v[1] = vv(1,0,-1); v[2] = vv(0,0,-1); v[3] = vv(0,-1,-1);
    launch(v[0], v[1], v[2], v[3], 10, 10, 10, 10, 4'b1001, 1'b0);
    check("R4 busy", 32'(busy), 32'h1);
    wait_to(2);
    vec_list = '1; dwell_list = '0;  // R3: late input changes must not matter
    wait_to(3); check("R7 first turn-on waits", 32'(gates), 32'h0);
    wait_to(4); check("R1 decode entry0 (mask ignored, R8)", 32'(gates), 32'(gx(v[0])));
    for (int k = 1; k < 4; k++) begin
      wait_to(10*k);     check("R4 hold previous", 32'(gates), 32'(gx(v[k-1])));
      wait_to(10*k + 1); check("R7 off first", 32'(gates), 32'(gx(v[k-1]) & gx(v[k])));
      wait_to(10*k + 3); check("R7 on still waiting", 32'(gates), 32'(gx(v[k-1]) & gx(v[k])));
      wait_to(10*k + 4); check("R1 decode entry", 32'(gates), 32'(gx(v[k])));
    end
    wait_to(39); check("R6 no early done", 32'(done), 32'h0);
    wait_to(40); check("R6 done pulse", 32'(done), 32'h1);
    check("R6 busy low", 32'(busy), 32'h0);
    wait_to(41); check("R6 done single", 32'(done), 32'h0);
    wait_to(60); check("R6 R3 gates hold", 32'(gates), 32'(gx(v[3])));
  endtask

  task automatic t_zero_dwell();
    logic [5:0] a, b;
    a = vv(1,0,0); b = vv(0,0,-1);
    launch(a, vv(1,0,-1), b, vv(1,1,1), 5, 0, 6, 0, 4'b0000, 1'b0);
    wait_to(5); check("R5 first entry", 32'(gates), 32'(gx(a)));
    wait_to(6); check("R5 skip to third", 32'(gates), 32'(gx(a) & gx(b)));
    wait_to(9); check("R5 third settled", 32'(gates), 32'(gx(b)));
    wait_to(10); check("R6 done not yet", 32'(done), 32'h0);
    wait_to(11); check("R6 done after zero tail", 32'(done), 32'h1);
    wait_to(16); check("R5 zero-dwell last not played", 32'(gates), 32'(gx(b)));
    launch(vv(1,1,1), vv(1,1,1), vv(1,1,1), vv(1,1,1), 0, 0, 0, 0, 4'b0000, 1'b0);
    check("R6 all-zero done at start edge", 32'(done), 32'h1);
    wait_to(1); check("R6 all-zero single", 32'(done), 32'h0);
    wait_to(6); check("R5 all-zero gates unchanged", 32'(gates), 32'(gx(b)));
  endtask

  task automatic t_balance_swap();
    launch(vv(1,0,0), vv(1,0,-1), vv(0,0,-1), vv(0,-1,-1), 8, 8, 8, 8, 4'b1011, 1'b1);
    wait_to(4);  check("R8 entry0 swapped down", 32'(gates), 32'(gx(vv(0,-1,-1))));
    wait_to(12); check("R8 mixed entry unchanged", 32'(gates), 32'(gx(vv(1,0,-1))));
    wait_to(28); check("R8 entry3 swapped up", 32'(gates), 32'(gx(vv(1,0,0))));
    wait_to(32); check("R6 done swapped list", 32'(done), 32'h1);
  endtask

  task automatic t_step_error();
    launch(vv(1,0,0), vv(-1,0,0), vv(0,0,0), vv(0,0,0), 4, 4, 0, 0, 4'b0000, 1'b0);
    check("R9 no error same state", 32'(step_err), 32'h0);
    wait_to(3); check("R9 no error before", 32'(step_err), 32'h0);
    wait_to(4); check("R9 error pulse", 32'(step_err), 32'h1);
    wait_to(5); check("R9 error single", 32'(step_err), 32'h0);
    check("R11 leg A all off during jump", 32'(gates[3:0]), 32'h0);
    wait_to(8); check("R9 jumped state still played", 32'(gates), 32'(gx(vv(-1,0,0))));
    check("R6 done after jump list", 32'(done), 32'h1);
  endtask

  task automatic t_restart();
    launch(vv(0,0,0), vv(0,0,-1), vv(0,0,0), vv(0,0,0), 20, 20, 0, 0, 4'b0000, 1'b0);
    wait_to(6); check("R10 first list playing", 32'(gates), 32'(gx(vv(0,0,0))));
    launch(vv(0,-1,-1), vv(0,0,0), vv(0,0,0), vv(0,0,0), 3, 0, 0, 0, 4'b0000, 1'b0);
    wait_to(2); check("R10 no done yet", 32'(done), 32'h0);
    wait_to(3); check("R10 new list done", 32'(done), 32'h1);
    wait_to(4); check("R10 new entry settled", 32'(gates), 32'(gx(vv(0,-1,-1))));
    wait_to(36); check("R10 aborted list silent", {30'b0, done, busy}, 32'h0);
  endtask

  task automatic t_dead_variants();
    dead_ticks = 6'd0;
    launch(vv(0,0,-1), vv(0,0,0), vv(0,0,0), vv(0,0,0), 5, 0, 0, 0, 4'b0000, 1'b0);
    wait_to(1); check("R7 dead0 off", 32'(gates), 32'(gx(vv(0,-1,-1)) & gx(vv(0,0,-1))));
    wait_to(2); check("R7 dead0 on", 32'(gates), 32'(gx(vv(0,0,-1))));
    wait_to(8);
    dead_ticks = 6'd5;
    launch(vv(0,0,0), vv(0,0,0), vv(0,0,0), vv(0,0,0), 10, 0, 0, 0, 4'b0000, 1'b0);
    wait_to(6); check("R7 dead5 still waiting", 32'(gates), 32'(gx(vv(0,0,-1)) & gx(vv(0,0,0))));
    wait_to(7); check("R7 dead5 on", 32'(gates), 32'(gx(vv(0,0,0))));
    wait_to(12);
    dead_ticks = 6'd2;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_basic_sequence();
    t_zero_dwell();
    t_balance_swap();
    t_step_error();
    t_restart();
    t_dead_variants();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule